// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a small data cache placed between a processor port that moves one word per request and a next-level memory port that moves a whole line per request. Each processor request carries a byte address, a read/write flag, a write word and a byte-enable mask. The address is divided into a tag, a set index and a line offset. The index picks one of the sets. Both ways of that set are compared at once to decide between a hit and a miss.

Writes stay in the cache and mark the line as modified. A write that misses first brings the whole line in and then merges the write into it. On a miss the controller picks a victim way in the selected set. A free way is taken first; otherwise the least-recently-used way is taken. A modified victim is copied out to memory before the request for the new line goes out. The processor port takes one request at a time and lowers its ready signal until the response has been given.

Top module: `wb_cache2w`

## Requirements
- R1: After reset every line is invalid and clean: `req_ready` is high, `resp_valid` and `mem_req_valid` are low, and the first access to any address misses.
- R2: With the default geometry, address bits [2:0] form the line offset, bits [4:3] the set index and bits [15:5] the tag. Bit 2 selects the word within the line. Bits [1:0] are ignored, so an access returns or updates the aligned word that contains the byte.
- R3: A request hits when a valid way of the selected set holds the request's tag. For a hit, `resp_valid` rises at the first rising edge after the edge that accepted the request, and no memory request is issued.
- R4: Read data is the aligned 4-byte word in little-endian order: byte lane b of `resp_rdata` (bits 8b+7..8b) holds the byte at word address + b. The returned value reflects every earlier write.
- R5: On a write hit, only the byte lanes whose `req_mask` bit is 1 are replaced and the other lanes keep their value. The memory port is not used.
- R6: On a write miss, the line is first read from memory and the write is then merged into it. A line filled by a read miss stays clean.
- R7: When the victim line is modified, exactly one line write of its complete current contents to {victim tag, index, 000} is issued, and it is issued before the line read. A clean victim causes no line write.
- R8: The victim is the lowest-numbered invalid way of the set. When both ways are valid, the victim is the way not used by the most recent hit or fill in that set. A set accessed as A,B,A,C,A,B,B,C with three blocks misses exactly five times from reset.
- R9: `req_ready` is low from the cycle after acceptance through the cycle in which `resp_valid` is high. `resp_valid` is a single-cycle pulse per request, and `req_ready` is high again in the next cycle.
- R10: A memory request holds `mem_req_valid`, `mem_addr`, `mem_write` and `mem_wdata` stable until `mem_req_ready` is sampled high. Line addresses have offset bits zero. Fill data is taken from a `mem_rvalid` pulse that follows the read handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8*WORD_BYTES | Write word |
| req_mask | input | WORD_BYTES | Byte enables for a write |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 8*WORD_BYTES | Read word (merged word for a write) |
| mem_req_valid | output | 1 | Line request to memory present |
| mem_req_ready | input | 1 | Memory accepts the line request |
| mem_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | 8*LINE_BYTES | Line written back |
| mem_rvalid | input | 1 | Line read data valid |
| mem_rdata | input | 8*LINE_BYTES | Line read data |

## Verification
Each response has a fixed point in time. A hit raises `resp_valid` one edge after acceptance. A miss takes longer, depending on how quickly memory accepts its requests, and its response is found by polling the output once per cycle. The bench drives and samples on falling edges and counts those edges from acceptance. A hit must show its response on exactly the second falling edge, and `resp_valid` must be low and `req_ready` high on the edge after the response. The memory model raises ready only after holding off one cycle, so it can check that a stalled request is held, and it counts line reads and write-backs per access against a reference cache model and a byte-array memory.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_COMPARE   = 3'd1,
    ST_WRITEBACK = 3'd2,
    ST_FILL      = 3'd3,
    ST_RESPOND   = 3'd4
  } wbc_state_e;

  localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
  parameter int TAG_W = 11,
  parameter int IDX_W = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [IDX_W-1:0]                       idx,
  input  logic [TAG_W-1:0]                       tag,
  output logic [wbc_pkg::NUM_WAYS-1:0]           hit_vec,
  output logic [wbc_pkg::NUM_WAYS-1:0]           valid_vec,
  output logic [wbc_pkg::NUM_WAYS-1:0]           dirty_vec,
  output logic [wbc_pkg::NUM_WAYS-1:0][TAG_W-1:0] tag_rd,
  output logic                                   lru_way,
  input  logic                                   fill_en,
  input  logic                                   fill_way,
  input  logic                                   dirty_en,
  input  logic                                   dirty_way,
  input  logic                                   touch_en,
  input  logic                                   touch_way
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < wbc_pkg::NUM_WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             fill_me;
    logic             dirty_me;

    assign fill_me  = fill_en  && (fill_way  == 1'(w));
    assign dirty_me = dirty_en && (dirty_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_me) begin
        vld_q[idx] <= 1'b1;
        drt_q[idx] <= 1'b0;
      end else if (dirty_me) begin
        drt_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_me) tag_q[idx] <= tag;
    end

    assign valid_vec[w] = vld_q[idx];
    assign dirty_vec[w] = drt_q[idx];
    assign tag_rd[w]    = tag_q[idx];
    assign hit_vec[w]   = vld_q[idx] && (tag_q[idx] == tag);
  end

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (touch_en) begin
      lru_q[idx] <= ~touch_way;
    end
  end

  assign lru_way = lru_q[idx];

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en |=> valid_vec[$past(dirty_way)] || ($past(idx) != idx)); // R5
endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
  parameter int IDX_W      = 2,
  parameter int LINE_BYTES = 8,
  parameter int WORD_BYTES = 4,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int WPL       = LINE_BYTES / WORD_BYTES,
  localparam int WSEL_W    = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic                                    clk,
  input  logic [IDX_W-1:0]                        idx,
  input  logic                                    fill_en,
  input  logic                                    fill_way,
  input  logic [LINE_W-1:0]                       fill_line,
  input  logic                                    wr_en,
  input  logic                                    wr_way,
  input  logic [WSEL_W-1:0]                       wr_sel,
  input  logic [WORD_BYTES-1:0]                   wr_mask,
  input  logic [WORD_W-1:0]                       wr_data,
  output logic [wbc_pkg::NUM_WAYS-1:0][LINE_W-1:0] line_rd
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < wbc_pkg::NUM_WAYS; w++) begin : g_way
    logic [LINE_W-1:0] mem_q [SETS];
    logic              fill_me;
    logic              wr_me;

    assign fill_me = fill_en && (fill_way == 1'(w));
    assign wr_me   = wr_en   && (wr_way   == 1'(w));

    always_ff @(posedge clk) begin
      if (fill_me) begin
        mem_q[idx] <= fill_line;
      end else if (wr_me) begin
        for (int b = 0; b < WORD_BYTES; b++) begin
          if (wr_mask[b]) begin
            mem_q[idx][(int'(wr_sel) * WORD_BYTES + b) * 8 +: 8] <= wr_data[b*8 +: 8];
          end
        end
      end
    end

    assign line_rd[w] = mem_q[idx];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int IDX_W      = 2,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int BOFF_W    = $clog2(WORD_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int WPL       = LINE_BYTES / WORD_BYTES,
  localparam int WSEL_W    = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic                             req_write,
  input  logic [ADDR_W-1:BOFF_W]           req_waddr,
  input  logic [WORD_W-1:0]                req_wdata,
  input  logic [WORD_BYTES-1:0]            req_mask,
  output logic                             resp_valid,
  output logic [WORD_W-1:0]                resp_rdata,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic                             mem_write,
  output logic [ADDR_W-1:0]                mem_addr,
  output logic [LINE_W-1:0]                mem_wdata,
  input  logic                             mem_rvalid,
  output logic [IDX_W-1:0]                 idx,
  output logic [TAG_W-1:0]                 tag,
  input  logic [NUM_WAYS-1:0]              hit_vec,
  input  logic [NUM_WAYS-1:0]              valid_vec,
  input  logic [NUM_WAYS-1:0]              dirty_vec,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0]   tag_rd,
  input  logic                             lru_way,
  input  logic [NUM_WAYS-1:0][LINE_W-1:0]  line_rd,
  output logic                             fill_en,
  output logic                             fill_way,
  output logic                             dirty_en,
  output logic                             dirty_way,
  output logic                             touch_en,
  output logic                             touch_way,
  output logic                             wr_en,
  output logic                             wr_way,
  output logic [WSEL_W-1:0]                wr_sel,
  output logic [WORD_BYTES-1:0]            wr_mask,
  output logic [WORD_W-1:0]                wr_data
);
  wbc_state_e st_q, st_d;

  logic [ADDR_W-1:BOFF_W]  a_q;
  logic                    w_q;
  logic [WORD_W-1:0]       d_q;
  logic [WORD_BYTES-1:0]   m_q;
  logic                    vic_q, vic_d;
  logic                    sent_q, sent_d;
  logic [WORD_W-1:0]       rd_q, rd_d;
  logic                    rd_load;
  logic                    accept;
  logic                    hit;
  logic                    hit_way;
  logic                    victim;
  logic [WSEL_W-1:0]       wsel;
  logic [LINE_W-1:0]       hit_line;
  logic [WORD_W-1:0]       old_word;
  logic [WORD_W-1:0]       merged;

  // ---------------- request decode ----------------
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign idx       = a_q[OFF_W +: IDX_W];
  assign tag       = a_q[ADDR_W-1 -: TAG_W];

  if (WPL > 1) begin : g_wsel
    assign wsel = a_q[BOFF_W +: WSEL_W];
  end else begin : g_wsel_one
    assign wsel = '0;
  end

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  // free way first (lowest index), then least recently used
  always_comb begin
    if (!valid_vec[0])      victim = 1'b0;
    else if (!valid_vec[1]) victim = 1'b1;
    else                    victim = lru_way;
  end

  assign hit_line = line_rd[hit_way];
  assign old_word = hit_line[int'(wsel) * WORD_W +: WORD_W];

  always_comb begin
    merged = old_word;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (m_q[b]) merged[b*8 +: 8] = d_q[b*8 +: 8];
    end
  end

  // ---------------- next-state logic ----------------
  always_comb begin
    st_d      = st_q;
    vic_d     = vic_q;
    sent_d    = sent_q;
    rd_d      = rd_q;
    rd_load   = 1'b0;
    fill_en   = 1'b0;
    dirty_en  = 1'b0;
    touch_en  = 1'b0;
    touch_way = hit_way;
    wr_en     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) st_d = ST_COMPARE;
      end
      ST_COMPARE: begin
        if (hit) begin
          touch_en = 1'b1;
          rd_load  = 1'b1;
          rd_d     = w_q ? merged : old_word;
          wr_en    = w_q;
          dirty_en = w_q;
          st_d     = ST_RESPOND;
        end else begin
          vic_d  = victim;
          sent_d = 1'b0;
          st_d   = (valid_vec[victim] && dirty_vec[victim]) ? ST_WRITEBACK : ST_FILL;
        end
      end
      ST_WRITEBACK: begin
        if (mem_req_ready) st_d = ST_FILL;
      end
      ST_FILL: begin
        if (!sent_q && mem_req_ready) sent_d = 1'b1;
        if (sent_q && mem_rvalid) begin
          fill_en   = 1'b1;
          touch_en  = 1'b1;
          touch_way = vic_q;
          sent_d    = 1'b0;
          st_d      = ST_COMPARE;
        end
      end
      ST_RESPOND: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      vic_q  <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      vic_q  <= vic_d;
      sent_q <= sent_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q <= req_waddr;
      w_q <= req_write;
      d_q <= req_wdata;
      m_q <= req_mask;
    end
    if (rd_load) rd_q <= rd_d;
  end

  // ---------------- outputs ----------------
  assign resp_valid    = (st_q == ST_RESPOND);
  assign resp_rdata    = rd_q;
  assign mem_req_valid = (st_q == ST_WRITEBACK) || ((st_q == ST_FILL) && !sent_q);
  assign mem_write     = (st_q == ST_WRITEBACK);
  assign mem_addr      = {(st_q == ST_WRITEBACK) ? tag_rd[vic_q] : tag, idx, {OFF_W{1'b0}}};
  assign mem_wdata     = line_rd[vic_q];

  assign fill_way  = vic_q;
  assign dirty_way = hit_way;
  assign wr_way    = hit_way;
  assign wr_sel    = wsel;
  assign wr_mask   = m_q;
  assign wr_data   = d_q;

  // ---------------- assertions ----------------
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R10

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !resp_valid); // R9

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_write |-> valid_vec[vic_q] && dirty_vec[vic_q]); // R7

  AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_write && mem_req_ready |=> mem_req_valid && !mem_write); // R7

  AST_REFILL_HITS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> hit_vec[vic_q] && !dirty_vec[vic_q]); // R6

  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (st_q == ST_COMPARE) |=> resp_valid && !mem_req_valid); // R3
endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int SETS       = 4,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  input  logic [WORD_BYTES-1:0] req_mask,
  output logic                  resp_valid,
  output logic [WORD_W-1:0]     resp_rdata,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [LINE_W-1:0]     mem_wdata,
  input  logic                  mem_rvalid,
  input  logic [LINE_W-1:0]     mem_rdata
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BOFF_W = $clog2(WORD_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WPL    = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W = (WPL > 1) ? $clog2(WPL) : 1;
  localparam int NW     = wbc_pkg::NUM_WAYS;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // byte-within-word address bits take no part in the access
  logic unused_byte_bits;
  assign unused_byte_bits = ^req_addr[BOFF_W-1:0];

  logic [IDX_W-1:0]              idx;
  logic [TAG_W-1:0]              tag;
  logic [NW-1:0]                 hit_vec, valid_vec, dirty_vec;
  logic [NW-1:0][TAG_W-1:0]      tag_rd;
  logic                          lru_way;
  logic [NW-1:0][LINE_W-1:0]     line_rd;
  logic                          fill_en, fill_way, dirty_en, dirty_way;
  logic                          touch_en, touch_way, wr_en, wr_way;
  logic [WSEL_W-1:0]             wr_sel;
  logic [WORD_BYTES-1:0]         wr_mask;
  logic [WORD_W-1:0]             wr_data;

  wbc_ctrl #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_waddr(req_addr[ADDR_W-1:BOFF_W]), .req_wdata(req_wdata), .req_mask(req_mask),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .idx(idx), .tag(tag), .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .tag_rd(tag_rd), .lru_way(lru_way), .line_rd(line_rd),
    .fill_en(fill_en), .fill_way(fill_way), .dirty_en(dirty_en), .dirty_way(dirty_way),
    .touch_en(touch_en), .touch_way(touch_way), .wr_en(wr_en), .wr_way(wr_way),
    .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_data(wr_data)
  );

  wbc_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_core_n), .idx(idx), .tag(tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .tag_rd(tag_rd), .lru_way(lru_way),
    .fill_en(fill_en), .fill_way(fill_way), .dirty_en(dirty_en), .dirty_way(dirty_way),
    .touch_en(touch_en), .touch_way(touch_way)
  );

  wbc_data_array #(.IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_data (
    .clk(clk), .idx(idx),
    .fill_en(fill_en), .fill_way(fill_way), .fill_line(mem_rdata),
    .wr_en(wr_en), .wr_way(wr_way), .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_data(wr_data),
    .line_rd(line_rd)
  );
endmodule

// File: tb/sim_wb_cache2w.sv
module sim_wb_cache2w;
  localparam int MEMB = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_mask;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_write;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;

  always #2 clk = ~clk;

  wb_cache2w u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] gold [MEMB];
  logic [7:0] back [MEMB];

  // reference cache state: 4 sets x 2 ways
  logic        mv [4][2];
  logic        md [4][2];
  logic [10:0] mt [4][2];
  logic        ml [4];

  int n_rd, n_wr, miss_obs;
  bit order_bad;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] line_of(input bit use_gold, input int base);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = use_gold ? gold[base + b] : back[base + b];
    return r;
  endfunction

  // ---------------- memory model ----------------
  int          hold, rcnt;
  logic [15:0] raddr, held_addr;
  bit          held_chk;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rvalid    = 1'b0;
      mem_rdata     = '0;
      hold          = 1;
      rcnt          = 0;
      held_chk      = 0;
    end else begin
      if (held_chk) begin
        chk(mem_req_valid && mem_addr == held_addr, "R10 request held while stalled",
            {48'd0, mem_addr}, {48'd0, held_addr});
        held_chk = 0;
      end
      mem_rvalid = 1'b0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = line_of(0, int'(raddr[9:0]));
        end
      end
      mem_req_ready = 1'b0;
      if (mem_req_valid) begin
        if (hold > 0) begin
          hold--;
          held_addr = mem_addr;
          held_chk  = 1;
        end else begin
          mem_req_ready = 1'b1;
          hold = 1;
          chk(mem_addr[2:0] == 3'd0, "R10 line address aligned", {61'd0, mem_addr[2:0]}, 64'd0);
          if (mem_write) begin
            n_wr++;
            if (n_rd > 0) order_bad = 1;
            chk(mem_wdata == line_of(1, int'(mem_addr[9:0])), "R7 write-back contents",
                mem_wdata, line_of(1, int'(mem_addr[9:0])));
            for (int b = 0; b < 8; b++) back[int'(mem_addr[9:0]) + b] = mem_wdata[b*8 +: 8];
          end else begin
            n_rd++;
            raddr = mem_addr;
            rcnt  = 2;
          end
        end
      end
    end
  end

  // ---------------- one processor access ----------------
  task automatic access(input logic [15:0] addr, input bit wr, input logic [31:0] wd,
                        input logic [3:0] mk, input string rtag);
    int s, n, pway, pv;
    bit phit, pwb;
    logic [10:0] tg;
    logic [31:0] exp;
    int base;
    s    = int'(addr[4:3]);
    tg   = addr[15:5];
    phit = 0; pway = 0;
    for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == tg) begin phit = 1; pway = w; end
    pv  = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(ml[s]));
    pwb = !phit && mv[s][pv] && md[s][pv];
    n_rd = 0; n_wr = 0; order_bad = 0;

    @(negedge clk);
    chk(req_ready, "R9 ready before request", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_mask = mk;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!resp_valid && n < 100) begin
      chk(!req_ready, "R9 ready low while busy", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      n++;
    end
    chk(resp_valid && !req_ready, "R9 response with ready low", {62'd0, resp_valid, req_ready}, 64'd2);
    if (phit) begin
      chk(n == 2, "R3 hit response timing", 64'(n), 64'd2);
      chk(n_rd == 0 && n_wr == 0, wr ? "R5 write hit no memory traffic" : "R3 hit no memory traffic",
          64'(n_rd + n_wr), 64'd0);
    end else begin
      chk(n_rd == 1, wr ? "R6 write miss fetches line" : "R8 miss fetches line", 64'(n_rd), 64'd1);
      chk(n_wr == int'(pwb), "R7 write-back count", 64'(n_wr), 64'(pwb));
      chk(!order_bad, "R7 write-back before fetch", {63'd0, order_bad}, 64'd0);
    end
    base = int'({addr[9:2], 2'b00});
    if (!wr) begin
      for (int b = 0; b < 4; b++) exp[b*8 +: 8] = gold[base + b];
      chk(resp_rdata == exp, rtag, {32'd0, resp_rdata}, {32'd0, exp});
    end else begin
      for (int b = 0; b < 4; b++) if (mk[b]) gold[base + b] = wd[b*8 +: 8];
    end
    if (phit) begin
      if (wr) md[s][pway] = 1;
      ml[s] = ~1'(pway);
    end else begin
      mv[s][pv] = 1; mt[s][pv] = tg; md[s][pv] = wr; ml[s] = ~1'(pv);
      miss_obs += n_rd;
    end
    @(negedge clk);
    chk(!resp_valid && req_ready, "R9 single response pulse", {62'd0, resp_valid, req_ready}, 64'd1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] lf;
    int m0;
    for (int i = 0; i < MEMB; i++) begin gold[i] = 8'(i * 37 + 5); back[i] = 8'(i * 37 + 5); end
    for (int s = 0; s < 4; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = '0; end
    end
    miss_obs = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 reset outputs",
        {61'd0, req_ready, resp_valid, mem_req_valid}, 64'd4);

    // R1/R4: cold read sweep over 16 lines (every word)
    m0 = miss_obs;
    for (int a = 0; a < 128; a += 4) access(16'(a), 0, '0, '0, "R4 sweep read");
    chk(miss_obs - m0 == 16, "R1 cold misses once per line", 64'(miss_obs - m0), 64'd16);

    // R2: byte bits ignored, word bit selects word
    access(16'h0104, 0, '0, '0, "R2 aligned read");
    access(16'h0107, 0, '0, '0, "R2 byte bits ignored");
    access(16'h0101, 0, '0, '0, "R2 low word of line");

    // R5: write hit with partial masks
    access(16'h0104, 1, 32'hA1B2C3D4, 4'b0101, "");
    access(16'h0104, 0, '0, '0, "R5 masked write merge");
    access(16'h0100, 0, '0, '0, "R5 other word untouched");

    // R6: write miss allocates then merges
    access(16'h0208, 1, 32'h11223344, 4'b1110, "");
    access(16'h0208, 0, '0, '0, "R6 write-allocate merge");
    access(16'h020C, 0, '0, '0, "R6 rest of fetched line");

    // R8: conflict pattern in set 0, A,B,A,C,A,B,B,C -> 5 misses
    access(16'h0300, 0, '0, '0, "R4 reset set0 a");
    access(16'h0320, 0, '0, '0, "R4 reset set0 b");
    access(16'h0340, 0, '0, '0, "R4 reset set0 c");
    m0 = miss_obs;
    access(16'h0000, 0, '0, '0, "R8 A");
    access(16'h0020, 0, '0, '0, "R8 B");
    access(16'h0000, 0, '0, '0, "R8 A");
    access(16'h0040, 0, '0, '0, "R8 C");
    access(16'h0000, 0, '0, '0, "R8 A");
    access(16'h0020, 0, '0, '0, "R8 B");
    access(16'h0020, 0, '0, '0, "R8 B");
    access(16'h0040, 0, '0, '0, "R8 C");
    chk(miss_obs - m0 == 5, "R8 LRU conflict miss count", 64'(miss_obs - m0), 64'd5);

    // R7: dirty lines then evict them
    for (int k = 0; k < 4; k++) access(16'(16'h0080 + k * 32), 1, 32'(32'hC0DE0000 + k), 4'b1111, "");
    for (int k = 4; k < 8; k++) access(16'(16'h0080 + k * 32), 0, '0, '0, "R7 evicting read");
    for (int k = 0; k < 4; k++) access(16'(16'h0080 + k * 32), 0, '0, '0, "R7 written data returns");

    // mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access({6'd0, lf[9:0]}, lf[11], {lf, ~lf}, lf[15:12], "R4 random read");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule